// File: doc/BRIEF.md
# Four-Lane CRC16 Generator

This block computes the data-line CRC16 of a 4-bit-wide memory-card data bus, one independent CRC per lane, while the block's nibbles stream through it. Each enabled cycle consumes one nibble. Bit i of that nibble belongs to lane i. Each lane runs its own 16-bit register with the polynomial x^16 + x^12 + x^5 + 1, and all four registers advance in lockstep. A 512-byte block is 1024 nibbles, so a block's CRC is complete after 1024 enabled cycles.

The checksum is available in two layouts. The per-lane layout gives each lane's CRC as its own 16-bit field. The interleaved layout puts all four lanes' bit k together in nibble k, so that sending the value as 16 nibbles drives each lane with its own CRC bits. A built-in shifter does that sending. It captures the checksum on request and presents it most significant CRC bit first, one nibble per cycle. A compare output checks a received 64-bit CRC, in the interleaved layout, against the computed one.

A typical use is as follows. Pulse clear before a block. Stream the data nibbles with enable. Then either start the shifter to append the CRC on transmit, or apply the received CRC to the compare input on reception.

Top module: `quad_lane_crc16`

## Requirements
- R1: While synchronous reset `rst` is high, and in the first cycle after it, every lane CRC is zero and `sh_valid_o` is low.
- R2: On a clock edge with `en_i` high and `clr_i` low, each lane i updates with data bit `nib_i[i]`. The feedback f = `nib_i[i]` XOR crc[15]. The new crc = (crc << 1) XOR (f ? 16'h1021 : 0). Lanes do not affect one another.
- R3: With `en_i` and `clr_i` both low, every lane CRC keeps its value, whatever `nib_i` carries.
- R4: `clr_i` high sets all four lane CRCs to zero at the next edge, and it takes priority over `en_i` in the same cycle.
- R5: `lanes_o[16*i+15 : 16*i]` is the CRC of lane i.
- R6: `ilv_o[4*k+i]` equals bit k of lane i's CRC, so nibble k holds CRC bit k of all lanes.
- R7: A cycle with `shift_start_i` high captures the interleaved checksum. From the next cycle, `sh_valid_o` is high for exactly 16 cycles, and `sh_nib_o` shows nibble 15 first, down to nibble 0. Later stream updates do not alter the values being shifted. A new start while shifting restarts from the new capture.
- R8: `mism_o` is high exactly when `rx_crc_i` (interleaved layout, as in R6) differs from `ilv_o` in any bit. The output is combinational.
- R9: With all lanes cleared, feeding the ASCII bytes "123456789" on lane 0, MSB of each byte first (72 nibbles, other lanes zero), yields lane 0 CRC 16'h31C3. A full 1024-nibble block matches the R2 polynomial on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Zero all lane CRCs (block start) |
| en_i | input | 1 | Advance every lane by one data bit |
| nib_i | input | 4 | Data nibble, bit i for lane i |
| shift_start_i | input | 1 | Capture checksum and start shifting it out |
| rx_crc_i | input | 64 | Received CRC, interleaved layout |
| lanes_o | output | 64 | Per-lane CRCs, lane i in bits 16i+15..16i |
| ilv_o | output | 64 | Interleaved CRC, nibble k = bit k of each lane |
| sh_nib_o | output | 4 | Shifted-out CRC nibble |
| sh_valid_o | output | 1 | Shifter nibble is valid |
| mism_o | output | 1 | Received CRC differs from computed CRC |

## Verification
The bench sweeps all 16 single-nibble values from a cleared state. This catches a lane swap or a wrong tap, since each lane must show either zero or the bare polynomial. It runs the standard check string and a full 1024-nibble random block against a long-division reference, which a design with a misplaced feedback point or a reversed bit order fails. It asserts clear together with enable and expects zero, which catches a wrong priority. It keeps feeding data while the shifter runs and also restarts the shifter mid-way. A design that shifts the live register rather than a snapshot, or one that counts 15 or 17 nibbles, then shows wrong nibbles or a wrong valid length. It flips each of the 64 received-CRC bits alone, so a compare that ignores any bit position is exposed.

// File: rtl/qcrc_pkg.sv
package qcrc_pkg;
    localparam int unsigned LANES  = 4;
    localparam int unsigned CRC_W  = 16;
    localparam logic [15:0] POLY16 = 16'h1021;
    localparam int unsigned TOT_W  = LANES * CRC_W;

    typedef struct packed {
        logic             valid;
        logic [LANES-1:0] nib;
    } qcrc_beat_t;
endpackage

// File: rtl/qcrc_lane.sv
module qcrc_lane #(
    parameter int unsigned CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_d;
    logic             fb;

    always_comb begin
        fb    = bit_i ^ crc_q[CRC_W-1];
        crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            crc_q <= '0;
        end else if (en_i) begin
            crc_q <= crc_d;
        end
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/qcrc_weave.sv
module qcrc_weave #(
    parameter int unsigned LANES = 4,
    parameter int unsigned CRC_W = 16,
    localparam int unsigned TOT_W = LANES * CRC_W
) (
    input  logic [TOT_W-1:0] lanes_i,
    output logic [TOT_W-1:0] ilv_o
);
    for (genvar k = 0; k < CRC_W; k++) begin : g_bit
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign ilv_o[k*LANES + i] = lanes_i[i*CRC_W + k];
        end
    end
endmodule

// File: rtl/qcrc_shifter.sv
module qcrc_shifter #(
    parameter int unsigned LANES = 4,
    parameter int unsigned CRC_W = 16,
    localparam int unsigned TOT_W = LANES * CRC_W,
    localparam int unsigned CNT_W = $clog2(CRC_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [TOT_W-1:0] load_i,
    output logic [LANES-1:0] nib_o,
    output logic             valid_o
);
    logic [TOT_W-1:0] sreg_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            cnt_q  <= '0;
        end else if (start_i) begin
            sreg_q <= load_i;
            cnt_q  <= CNT_W'(CRC_W);
        end else if (cnt_q != '0) begin
            sreg_q <= {sreg_q[TOT_W-LANES-1:0], {LANES{1'b0}}};
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign nib_o   = sreg_q[TOT_W-1 -: LANES];
    assign valid_o = (cnt_q != '0);
endmodule

// File: rtl/qcrc_match.sv
module qcrc_match #(
    parameter int unsigned LANES = 4,
    parameter int unsigned CRC_W = 16,
    localparam int unsigned TOT_W = LANES * CRC_W
) (
    input  logic [TOT_W-1:0] calc_i,
    input  logic [TOT_W-1:0] rx_i,
    output logic             mism_o
);
    logic [CRC_W-1:0] per_bit;

    for (genvar k = 0; k < CRC_W; k++) begin : g_nib
        assign per_bit[k] = |(calc_i[k*LANES +: LANES] ^ rx_i[k*LANES +: LANES]);
    end

    assign mism_o = |per_bit;
endmodule

// File: rtl/quad_lane_crc16.sv
module quad_lane_crc16
    import qcrc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [LANES-1:0] nib_i,
    input  logic             shift_start_i,
    input  logic [TOT_W-1:0] rx_crc_i,
    output logic [TOT_W-1:0] lanes_o,
    output logic [TOT_W-1:0] ilv_o,
    output logic [LANES-1:0] sh_nib_o,
    output logic             sh_valid_o,
    output logic             mism_o
);
    qcrc_beat_t beat;

    assign beat.valid = en_i;
    assign beat.nib   = nib_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qcrc_lane #(
            .CRC_W(CRC_W),
            .POLY (POLY16)
        ) u_lane (
            .clk  (clk),
            .rst  (rst),
            .clr_i(clr_i),
            .en_i (beat.valid),
            .bit_i(beat.nib[g]),
            .crc_o(lanes_o[g*CRC_W +: CRC_W])
        );
    end

    qcrc_weave #(.LANES(LANES), .CRC_W(CRC_W)) u_weave (
        .lanes_i(lanes_o),
        .ilv_o  (ilv_o)
    );

    qcrc_shifter #(.LANES(LANES), .CRC_W(CRC_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .start_i(shift_start_i),
        .load_i (ilv_o),
        .nib_o  (sh_nib_o),
        .valid_o(sh_valid_o)
    );

    qcrc_match #(.LANES(LANES), .CRC_W(CRC_W)) u_match (
        .calc_i(ilv_o),
        .rx_i  (rx_crc_i),
        .mism_o(mism_o)
    );
endmodule

// File: rtl/qcrc_checker.sv
module qcrc_checker
    import qcrc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr_i,
    input logic             en_i,
    input logic [LANES-1:0] nib_i,
    input logic             shift_start_i,
    input logic [TOT_W-1:0] lanes_o,
    input logic [TOT_W-1:0] ilv_o,
    input logic [LANES-1:0] sh_nib_o,
    input logic             sh_valid_o
);
    logic [LANES-1:0] top_bits;
    logic [TOT_W-1:0] rebuilt;
    logic [5:0]       run_q;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            top_bits[i] = lanes_o[i*CRC_W + CRC_W - 1];
            for (int k = 0; k < CRC_W; k++) begin
                rebuilt[k*LANES + i] = lanes_o[i*CRC_W + k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || shift_start_i) run_q <= '0;
        else if (sh_valid_o)      run_q <= run_q + 6'd1;
        else                      run_q <= '0;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (lanes_o == '0 && !sh_valid_o));

    a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (lanes_o == '0));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !clr_i) |=> $stable(lanes_o));

    a_r2_zero_stays_zero: assert property (@(posedge clk) disable iff (rst)
        (en_i && !clr_i && nib_i == '0 && lanes_o == '0) |=> (lanes_o == '0));

    a_r6_weave: assert property (@(posedge clk) disable iff (rst)
        ilv_o == rebuilt);

    a_r7_first_nibble: assert property (@(posedge clk) disable iff (rst)
        shift_start_i |=> (sh_valid_o && sh_nib_o == $past(top_bits)));

    a_r7_run_length: assert property (@(posedge clk) disable iff (rst)
        run_q <= 6'(CRC_W));
endmodule

bind quad_lane_crc16 qcrc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .clr_i        (clr_i),
    .en_i         (en_i),
    .nib_i        (nib_i),
    .shift_start_i(shift_start_i),
    .lanes_o      (lanes_o),
    .ilv_o        (ilv_o),
    .sh_nib_o     (sh_nib_o),
    .sh_valid_o   (sh_valid_o)
);

// File: tb/test_quad_lane_crc16.sv
`timescale 1ns/1ps
module test_quad_lane_crc16;
    localparam int LN = 4;
    localparam int CW = 16;
    localparam int TW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          en  = 1'b0;
    logic          sst = 1'b0;
    logic [LN-1:0] nib = '0;
    logic [TW-1:0] rx  = '0;
    logic [TW-1:0] lanes_o, ilv_o;
    logic [LN-1:0] sh_nib_o;
    logic          sh_valid_o, mism_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    bit msg [LN][0:2047];
    int mlen  = 0;

    always #2 clk = ~clk;

    quad_lane_crc16 i_quad_lane_crc16 (
        .clk(clk), .rst(rst), .clr_i(clr), .en_i(en), .nib_i(nib),
        .shift_start_i(sst), .rx_crc_i(rx), .lanes_o(lanes_o), .ilv_o(ilv_o),
        .sh_nib_o(sh_nib_o), .sh_valid_o(sh_valid_o), .mism_o(mism_o)
    );

    // reference: remainder of (message * x^16) divided by the generator
    function automatic logic [15:0] div_crc(int lane);
        logic [16:0] rem = '0;
        for (int j = 0; j < mlen + 16; j++) begin
            rem = {rem[15:0], (j < mlen) ? msg[lane][j] : 1'b0};
            if (rem[16]) rem = rem ^ 17'h11021;
        end
        return rem[15:0];
    endfunction

    function automatic logic [TW-1:0] exp_lanes();
        logic [TW-1:0] v;
        for (int i = 0; i < LN; i++) v[i*CW +: CW] = div_crc(i);
        return v;
    endfunction

    function automatic logic [TW-1:0] weave(logic [TW-1:0] l);
        logic [TW-1:0] v;
        for (int k = 0; k < CW; k++)
            for (int i = 0; i < LN; i++) v[k*LN + i] = l[i*CW + k];
        return v;
    endfunction

    task automatic chk(string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        mlen = 0;
    endtask

    task automatic feed(logic [LN-1:0] v);
        en = 1'b1;
        nib = v;
        for (int i = 0; i < LN; i++) msg[i][mlen] = v[i];
        mlen++;
        @(negedge clk);
        en = 1'b0;
    endtask

    task automatic check_state(string tag);
        logic [TW-1:0] e = exp_lanes();
        chk({tag, " lanes"}, lanes_o, e);
        chk({"R6 ", tag, " interleave"}, ilv_o, weave(e));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] snap;
        logic [71:0] str;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset lanes", lanes_o, '0);
        chk("R1 reset valid", {63'b0, sh_valid_o}, '0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset lanes", lanes_o, '0);

        // R2/R5 exhaustive single nibble from clear
        for (int v = 0; v < 16; v++) begin
            do_clear();
            feed(4'(v));
            check_state("R2 R5 single nibble");
        end

        // R9 check string on lane 0
        do_clear();
        str = "123456789";
        for (int j = 71; j >= 0; j--) feed({3'b000, str[j]});
        chk("R9 check string lane0", {48'b0, lanes_o[15:0]}, 64'h31C3);
        chk("R9 check string other lanes", {16'b0, lanes_o[63:16]}, '0);

        // R2 random streams of several lengths, incl. full block (R9)
        for (int t = 0; t < 4; t++) begin
            int len = (t == 0) ? 1 : (t == 1) ? 7 : (t == 2) ? 33 : 1024;
            do_clear();
            for (int j = 0; j < len; j++) feed(4'($urandom));
            check_state(t == 3 ? "R9 full block" : "R2 random stream");
        end

        // R3 hold with enable low
        snap = lanes_o;
        nib = 4'hF;
        repeat (5) @(negedge clk);
        chk("R3 hold", lanes_o, snap);

        // R4 clear wins over enable
        clr = 1'b1; en = 1'b1; nib = 4'hF;
        @(negedge clk);
        clr = 1'b0; en = 1'b0; mlen = 0;
        chk("R4 clear priority", lanes_o, '0);

        // R7 shift-out with stream running underneath
        for (int j = 0; j < 20; j++) feed(4'($urandom));
        snap = weave(exp_lanes());
        sst = 1'b1;
        @(negedge clk);
        sst = 1'b0;
        for (int k = 15; k >= 0; k--) begin
            chk("R7 valid", {63'b0, sh_valid_o}, 64'd1);
            chk("R7 nibble", {60'b0, sh_nib_o}, {60'b0, snap[k*LN +: LN]});
            feed(4'hF);
        end
        chk("R7 valid ends", {63'b0, sh_valid_o}, '0);
        check_state("R7 stream continues");

        // R7 restart while shifting
        sst = 1'b1;
        @(negedge clk);
        sst = 1'b0;
        for (int j = 0; j < 3; j++) feed(4'($urandom));
        snap = weave(exp_lanes());
        sst = 1'b1;
        @(negedge clk);
        sst = 1'b0;
        for (int k = 15; k >= 0; k--) begin
            chk("R7 restart nibble", {59'b0, sh_valid_o, sh_nib_o},
                {59'b0, 1'b1, snap[k*LN +: LN]});
            @(negedge clk);
        end
        chk("R7 restart valid ends", {63'b0, sh_valid_o}, '0);

        // R8 compare: match, then every single-bit flip
        snap = weave(exp_lanes());
        rx = snap;
        #1;
        chk("R8 match", {63'b0, mism_o}, '0);
        for (int b = 0; b < TW; b++) begin
            rx = snap ^ (64'd1 << b);
            #1;
            chk("R8 flip", {63'b0, mism_o}, 64'd1);
        end
        rx = '0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule